// File: doc/BRIEF.md
# Half-Bridge Dead-Time Controller

This block turns the commanded high-side and low-side states of several half-bridge legs into the actual gate enables. A leg's two switches are never on together. When one switch of a leg turns off, the opposite switch of that leg is held off until a programmable number of timebase ticks has passed. The wait for a high-to-low changeover and the wait for a low-to-high changeover are set separately, so the two dead intervals can differ.

The commands arrive already gated by fault logic. A shared tick input advances the dead interval counters. A shared inhibit input forces every leg off. Each leg decides on its own and records which switch turned off last. A new turn-on is therefore judged against the switch that is currently off. A turn-off always takes effect on the next clock edge. A turn-on of the same switch that just went off needs no wait.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: In no leg are `en_hs` and `en_ls` high in the same cycle.
- R2: While a switch is enabled, dropping its command (or commanding the opposite switch alone) clears its enable on the next clock edge.
- R3: After the high side turns off, the low side of that leg is enabled only once `dt_hl` ticks have been counted. With the tick high every cycle, `en_ls` rises on the (`dt_hl`+1)-th edge after the edge that cleared `en_hs`.
- R4: After the low side turns off, the high side is enabled only once `dt_lh` ticks have been counted. With the tick high every cycle, `en_hs` rises on the (`dt_lh`+1)-th edge after the edge that cleared `en_ls`.
- R5: With both commands high, an enabled switch stays enabled, and a leg that has both switches off keeps both off.
- R6: Re-enabling the switch that turned off last needs no dead interval; it turns on at the next edge.
- R7: Reset clears all enables. The first turn-on after reset happens on the next edge, with no dead interval.
- R8: While `inhibit` is high, every enable is low from the next edge onward. The dead interval for the switch that the inhibit forced off still applies after release, counted from the forcing edge.
- R9: Dead-interval counts advance only in cycles with `tick` high. While `tick` is low, a waiting switch stays off.
- R10: With a dead-interval setting of 0, the opposite switch turns on on the second edge after the changeover command, so there is exactly one cycle with both switches off.
- R11: Each leg follows only its own `cmd_hs`/`cmd_ls` bit (bit i of each vector drives bit i of each enable vector).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inhibit | input | 1 | Forces all legs off while high |
| tick | input | 1 | Timebase strobe that advances the dead-interval counts |
| dt_hl | input | CNT_W | Ticks to wait from high-side off to low-side on |
| dt_lh | input | CNT_W | Ticks to wait from low-side off to high-side on |
| cmd_hs | input | NUM_LEGS | Commanded high-side state, one bit per leg |
| cmd_ls | input | NUM_LEGS | Commanded low-side state, one bit per leg |
| en_hs | output | NUM_LEGS | High-side gate enable, one bit per leg |
| en_ls | output | NUM_LEGS | Low-side gate enable, one bit per leg |

## Verification
The bench measures the exact edge on which the opposite switch turns on after a changeover, in both directions and with unequal settings. An off-by-one counter or a swapped pair of settings would move that edge. It drives both commands high from an enabled state and from the all-off state. A design that decodes this case naively would enable both switches or turn one on from idle. It also checks the cases around the dead interval: an immediate return to the same switch, an inhibit pulse in the middle of a changeover, a stalled tick, and a zero setting. A design that forgets which switch went off, that stops counting during inhibit, that counts clocks instead of ticks, or that overlaps at a zero setting fails one of these checks.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HS  = 2'd1,
      LEG_LS  = 2'd2
   } leg_state_e;

   typedef enum logic [1:0] {
      SIDE_NONE = 2'd0,
      SIDE_HS   = 2'd1,
      SIDE_LS   = 2'd2
   } side_e;
endpackage

// File: rtl/hbdt_dead_timer.sv
module hbdt_dead_timer
   import hbdt_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit TICK_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  side_e            side_in,
   input  logic             idle,
   input  logic             tick,
   input  logic [CNT_W-1:0] dt_hl,
   input  logic [CNT_W-1:0] dt_lh,
   output logic             ok_hs,
   output logic             ok_ls
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             advance;
   logic [CNT_W-1:0] cnt_q;
   side_e            last_q;

   generate
      if (TICK_GATED) begin : g_ticked
         assign advance = tick;
      end else begin : g_every_clk
         assign advance = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= SIDE_NONE;
      end else if (restart) begin
         cnt_q  <= '0;
         last_q <= side_in;
      end else if (idle && advance && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ok_hs = (last_q != SIDE_LS) || (cnt_q >= dt_lh);
   assign ok_ls = (last_q != SIDE_HS) || (cnt_q >= dt_hl);

   // A restart always names the side that went off (R3, R4)
   p_restart_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (side_in != SIDE_NONE));
endmodule

// File: rtl/hbdt_leg.sv
module hbdt_leg
   import hbdt_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit TICK_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inhibit,
   input  logic             tick,
   input  logic [CNT_W-1:0] dt_hl,
   input  logic [CNT_W-1:0] dt_lh,
   input  logic             cmd_hs,
   input  logic             cmd_ls,
   output logic             en_hs,
   output logic             en_ls
);
   localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};

   leg_state_e state_q, state_d;
   logic       restart;
   side_e      side_off;
   logic       ok_hs, ok_ls;

   hbdt_dead_timer #(
      .CNT_W      (CNT_W),
      .TICK_GATED (TICK_GATED)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .side_in (side_off),
      .idle    (state_q == LEG_OFF),
      .tick    (tick),
      .dt_hl   (dt_hl),
      .dt_lh   (dt_lh),
      .ok_hs   (ok_hs),
      .ok_ls   (ok_ls)
   );

   always_comb begin
      state_d  = state_q;
      restart  = 1'b0;
      side_off = SIDE_NONE;
      case (state_q)
         LEG_HS: begin
            if (inhibit || !cmd_hs) begin
               state_d  = LEG_OFF;
               restart  = 1'b1;
               side_off = SIDE_HS;
            end
         end
         LEG_LS: begin
            if (inhibit || !cmd_ls) begin
               state_d  = LEG_OFF;
               restart  = 1'b1;
               side_off = SIDE_LS;
            end
         end
         default: begin
            state_d = LEG_OFF;
            if (!inhibit) begin
               if (cmd_hs && !cmd_ls && ok_hs) begin
                  state_d = LEG_HS;
               end else if (cmd_ls && !cmd_hs && ok_ls) begin
                  state_d = LEG_LS;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LEG_OFF;
      end else begin
         state_q <= state_d;
      end
   end

   assign en_hs = (state_q == LEG_HS);
   assign en_ls = (state_q == LEG_LS);

   // ---------------- checker state: gaps seen at the enables ----------------
   logic             chk_adv;
   logic [CNT_W-1:0] gap_after_hs, gap_after_ls;
   logic             hs_seen, ls_seen;

   assign chk_adv = TICK_GATED ? tick : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_after_hs <= '0;
         gap_after_ls <= '0;
         hs_seen      <= 1'b0;
         ls_seen      <= 1'b0;
      end else begin
         if (en_hs) begin
            gap_after_hs <= '0;
            hs_seen      <= 1'b1;
         end else if (chk_adv && gap_after_hs != GAP_MAX) begin
            gap_after_hs <= gap_after_hs + 1'b1;
         end
         if (en_ls) begin
            gap_after_ls <= '0;
            ls_seen      <= 1'b1;
         end else if (chk_adv && gap_after_ls != GAP_MAX) begin
            gap_after_ls <= gap_after_ls + 1'b1;
         end
      end
   end

   p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_hs && en_ls));

   p_hs_off_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hs && !cmd_hs) |=> !en_hs);

   p_ls_off_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_ls && !cmd_ls) |=> !en_ls);

   p_hl_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_ls) |-> (!hs_seen || gap_after_hs >= dt_hl));

   p_lh_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_hs) |-> (!ls_seen || gap_after_ls >= dt_lh));

   p_both_hold_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hs && cmd_hs && cmd_ls && !inhibit) |=> en_hs);

   p_both_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_hs && !en_ls && cmd_hs && cmd_ls) |=> (!en_hs && !en_ls));

   p_inhibit_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> (!en_hs && !en_ls));
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
   parameter int NUM_LEGS   = 3,
   parameter int CNT_W      = 8,
   parameter bit TICK_GATED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inhibit,
   input  logic                tick,
   input  logic [CNT_W-1:0]    dt_hl,
   input  logic [CNT_W-1:0]    dt_lh,
   input  logic [NUM_LEGS-1:0] cmd_hs,
   input  logic [NUM_LEGS-1:0] cmd_ls,
   output logic [NUM_LEGS-1:0] en_hs,
   output logic [NUM_LEGS-1:0] en_ls
);
   generate
      if (NUM_LEGS < 1) begin : g_bad_legs
         $error("hb_deadtime_ctrl: NUM_LEGS must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("hb_deadtime_ctrl: CNT_W must lie in 2..24");
      end

      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         hbdt_leg #(
            .CNT_W      (CNT_W),
            .TICK_GATED (TICK_GATED)
         ) leg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inhibit (inhibit),
            .tick    (tick),
            .dt_hl   (dt_hl),
            .dt_lh   (dt_lh),
            .cmd_hs  (cmd_hs[g]),
            .cmd_ls  (cmd_ls[g]),
            .en_hs   (en_hs[g]),
            .en_ls   (en_ls[g])
         );
      end
   endgenerate
endmodule

// File: tb/hb_deadtime_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_tb_top;
   localparam int  NL    = 3;
   localparam int  CW    = 8;
   localparam real TCLK  = 20.0;
   localparam int  NVEC  = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inhibit = 1'b0;
   logic          tick = 1'b1;
   logic [CW-1:0] dt_hl = 8'd3;
   logic [CW-1:0] dt_lh = 8'd5;
   logic [NL-1:0] cmd_hs = '0;
   logic [NL-1:0] cmd_ls = '0;
   logic [NL-1:0] en_hs, en_ls;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  overlap_seen = 1'b0;
   bit  done = 1'b0;

   always #(TCLK/2) clk = ~clk;

   hb_deadtime_ctrl #(.NUM_LEGS(NL), .CNT_W(CW), .TICK_GATED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .tick(tick),
      .dt_hl(dt_hl), .dt_lh(dt_lh), .cmd_hs(cmd_hs), .cmd_ls(cmd_ls),
      .en_hs(en_hs), .en_ls(en_ls)
   );

   // row = {cmd_hs, cmd_ls, inhibit, tick, exp_hs, exp_ls}, leg 0, dt_hl=3, dt_lh=5
   localparam logic [5:0] VEC [NVEC] = '{
      6'b100110, // R7 first turn-on after reset is immediate
      6'b110110, // R5 both commanded, high side kept
      6'b010100, // R2 high side off next edge
      6'b010100, // R3 waiting
      6'b010100, // R3 waiting
      6'b010100, // R3 waiting
      6'b010101, // R3 low side on at edge dt_hl+1
      6'b110101, // R5 both commanded, low side kept
      6'b100100, // R2 low side off next edge
      6'b100100, // R4 waiting
      6'b100100, // R4 waiting
      6'b100100, // R4 waiting
      6'b100100, // R4 waiting
      6'b100100, // R4 waiting
      6'b100110, // R4 high side on at edge dt_lh+1
      6'b000100, // R2 high side off
      6'b100110, // R6 same side back with no wait
      6'b000100, // R2 off again
      6'b110100, // R5 both commanded from idle stays off
      6'b000100  // R1 idle
   };
   localparam int VREQ [NVEC] = '{7,5,2,3,3,3,3,5,2,4,4,4,4,4,4,2,6,2,5,1};

   task automatic chk2(input int req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: {hs,ls} got %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_int(input int req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL R%0d: got %0d expected %0d", req, act, exp);
      end
   endtask

   // edges until the chosen enable of a leg is high
   task automatic edges_to_on(input int leg, input bit want_hs, input int lim, output int n);
      n = -1;
      for (int k = 1; k <= lim; k++) begin
         @(negedge clk);
         if ((want_hs ? en_hs[leg] : en_ls[leg]) === 1'b1) begin
            n = k;
            break;
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && ((en_hs & en_ls) != '0)) overlap_seen = 1'b1;
   end

   initial begin
      #(TCLK * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL R1: watchdog expired, got timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      cmd_hs = '0;
      cmd_ls = '1;
      repeat (3) @(negedge clk);
      // R7: enables low during reset
      chk2(7, {|en_hs, |en_ls}, 2'b00);
      cmd_ls = '0;
      rst_n  = 1'b1;
      @(negedge clk);

      // table walk on leg 0
      for (int i = 0; i < NVEC; i++) begin
         cmd_hs[0] = VEC[i][5];
         cmd_ls[0] = VEC[i][4];
         inhibit   = VEC[i][3];
         tick      = VEC[i][2];
         @(negedge clk);
         chk2(VREQ[i], {en_hs[0], en_ls[0]}, VEC[i][1:0]);
      end

      // R8: inhibit mid-changeover keeps the dead interval
      cmd_hs[0] = 1'b1; cmd_ls[0] = 1'b0; inhibit = 1'b0; tick = 1'b1;
      @(negedge clk);
      chk2(8, {en_hs[0], en_ls[0]}, 2'b10);
      inhibit = 1'b1;
      @(negedge clk);
      chk2(8, {en_hs[0], en_ls[0]}, 2'b00);
      cmd_hs[0] = 1'b0; cmd_ls[0] = 1'b1;
      @(negedge clk);
      chk2(8, {en_hs[0], en_ls[0]}, 2'b00);
      inhibit = 1'b0;
      edges_to_on(0, 1'b0, 20, n);
      chk_int(8, n, 3);

      // R9: no tick, no progress
      cmd_hs[0] = 1'b1; cmd_ls[0] = 1'b0; tick = 1'b0;
      repeat (21) @(negedge clk);
      chk2(9, {en_hs[0], en_ls[0]}, 2'b00);
      tick = 1'b1;
      edges_to_on(0, 1'b1, 20, n);
      chk_int(9, n, 6);

      // R10: zero dead setting on fresh leg 1
      dt_hl = '0;
      cmd_hs[1] = 1'b1;
      @(negedge clk);
      chk2(10, {en_hs[1], en_ls[1]}, 2'b10);
      cmd_hs[1] = 1'b0; cmd_ls[1] = 1'b1;
      edges_to_on(1, 1'b0, 20, n);
      chk_int(10, n, 2);
      chk2(10, {en_hs[1], en_ls[1]}, 2'b01);

      // R11: fresh leg 2 acts alone, others hold
      cmd_ls[2] = 1'b1;
      @(negedge clk);
      chk2(11, {en_hs[2], en_ls[2]}, 2'b01);
      n_chk++;
      if (en_hs !== 3'b001 || en_ls !== 3'b110) begin
         n_fail++;
         $display("FAIL R11: hs=%b ls=%b expected hs=001 ls=110", en_hs, en_ls);
      end

      // R1: no overlap at any sampled cycle
      chk_int(1, int'(overlap_seen), 0);
      finish_run();
   end
endmodule